// File: doc/BRIEF.md
# Memory Device Boundary-Scan Test Port

This block is a serial test access port for a synchronous static memory. A five-state-bit-free, sixteen-state controller is stepped by TMS on each rising edge of TCK. It selects either a 3-bit instruction register or one of three data registers: a 1-bit pass-through register, a 32-bit identity word and a 75-bit boundary register. Selected bits leave LSB first on TDO. TDO is launched on the falling edge of TCK, so a board-level chain can sample it on the next rising edge.

There is no dedicated test-reset pin. The controller and the instruction register come up from a synchronous power-on reset supplied by the chip. After that, holding TMS high for five clocks always returns the port to its reset state. The boundary register takes a parallel snapshot of the device's input pins. Two of the boundary instructions also ask the memory core to float its data bus while they are active.

Top module: `sram_tap`

## Requirements
- R1: After power-on reset the port is in Test-Logic-Reset with instruction 3'b001 (identity) active, `tdo_en` low and `dq_hiz` low; a data scan then returns the identity word.
- R2: Five consecutive rising TCK edges with TMS high return the port to Test-Logic-Reset from any state, and the active instruction becomes 3'b001 again, whatever was loaded before.
- R3: Capture-IR loads the instruction shifter with 3'b001, shifted out LSB first.
- R4: The identity word places revision in bits 31:28, configuration in 27:18, vendor field in 17:12, manufacturer code in 11:1 and a constant 1 in bit 0; with default parameters it reads 32'h2290054B.
- R5: Codes 3'b011, 3'b101, 3'b110 and 3'b111 select the 1-bit pass-through register, which captures 0 in Capture-DR.
- R6: Codes 3'b000, 3'b010 and 3'b100 select the 75-bit boundary register, which captures `bscan_in` in Capture-DR and shifts out bit 0 first.
- R7: `dq_hiz` is high exactly while the active instruction is 3'b000 or 3'b010, and changes only on the edge that leaves Update-IR.
- R8: `tdo` and `tdo_en` change on the falling edge of TCK; `tdo_en` is high only in Shift-IR and Shift-DR.
- R9: A data register keeps its shifted contents through Exit1-DR, Pause-DR and Exit2-DR, so a resumed shift continues from the last TDI bit without a new capture.
- R10: A TDI bit shifted into the selected data register appears on TDO after exactly that register's length in shift cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_rst | input | 1 | Synchronous active-high power-on reset from the chip |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| bscan_in | input | 75 | Parallel snapshot of device pins for the boundary register |
| tdo | output | 1 | Serial data out, launched on falling TCK |
| tdo_en | output | 1 | High while TDO carries shifted data |
| dq_hiz | output | 1 | Request to the core to float its data bus |

## Verification
A corrupted controller state shows up at once as a misplaced `tdo_en` window or as a capture that loads the wrong register. It is visible within the first shifted bit of the next scan. A wrong active instruction appears at `dq_hiz` on the cycle after Update-IR. It also appears as a data scan whose length or captured contents differ, seen within one register length. A broken shifter or pause path shows as a TDO stream that is offset by one or more bits. Random instruction and data scans catch this by comparing each complete stream against the length and capture rules.

// File: rtl/sram_tap_pkg.sv
package sram_tap_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [3:0] {
        ST_TLR,  ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST  = 3'b000,
        OP_IDCODE  = 3'b001,
        OP_SAMPLEZ = 3'b010,
        OP_BYP_A   = 3'b011,
        OP_SAMPLE  = 3'b100,
        OP_RSVD    = 3'b101,
        OP_BYP_B   = 3'b110,
        OP_BYP_C   = 3'b111
    } tap_op_e;

    typedef enum logic [1:0] {
        SEL_BYP = 2'd0,
        SEL_ID  = 2'd1,
        SEL_BSR = 2'd2
    } dr_sel_e;

    typedef struct packed {
        dr_sel_e sel;
        logic    hiz;
    } op_decode_t;

    typedef struct packed {
        logic [3:0]  rev;
        logic [9:0]  cfg;
        logic [5:0]  vend;
        logic [10:0] mfr;
        logic        marker;
    } idcode_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        tap_state_e n;
        case (s)
            ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = tms ? ST_SEL_DR : ST_RTI;
            default:   n = ST_TLR;
        endcase
        return n;
    endfunction

    function automatic op_decode_t op_decode(input tap_op_e op);
        op_decode_t d;
        case (op)
            OP_EXTEST:  d = '{sel: SEL_BSR, hiz: 1'b1};
            OP_SAMPLEZ: d = '{sel: SEL_BSR, hiz: 1'b1};
            OP_SAMPLE:  d = '{sel: SEL_BSR, hiz: 1'b0};
            OP_IDCODE:  d = '{sel: SEL_ID,  hiz: 1'b0};
            default:    d = '{sel: SEL_BYP, hiz: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import sram_tap_pkg::*;
#(
    parameter int RESET_RUN = 5
) (
    input  logic       tck,
    input  logic       por_rst,
    input  logic       tms,
    output tap_state_e state
);
    localparam int CNT_W = $clog2(RESET_RUN + 1);

    always_ff @(posedge tck) begin
        if (por_rst) state <= ST_TLR;
        else         state <= tap_next(state, tms);
    end

    // independent count of consecutive high TMS samples
    logic [CNT_W-1:0] ones_cnt;
    always_ff @(posedge tck) begin
        if (por_rst)                                ones_cnt <= '0;
        else if (!tms)                              ones_cnt <= '0;
        else if (ones_cnt != CNT_W'(RESET_RUN))     ones_cnt <= ones_cnt + 1'b1;
    end

    // R2
    tms_reset_run_chk: assert property (@(posedge tck) disable iff (por_rst)
        (ones_cnt == CNT_W'(RESET_RUN)) |-> (state == ST_TLR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import sram_tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_rst,
    input  logic       tdi,
    input  tap_state_e state,
    output tap_op_e    ir_q,
    output logic       ir_lsb
);
    logic [IR_W-1:0] ir_sh;

    always_ff @(posedge tck) begin
        if (por_rst) begin
            ir_sh <= '0;
            ir_q  <= OP_IDCODE;
        end else begin
            case (state)
                ST_TLR:    ir_q  <= OP_IDCODE;
                ST_CAP_IR: ir_sh <= IR_CAPTURE;
                ST_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                ST_UPD_IR: ir_q  <= tap_op_e'(ir_sh);
                default: ;
            endcase
        end
    end

    assign ir_lsb = ir_sh[0];

    // R3
    ir_capture_chk: assert property (@(posedge tck) disable iff (por_rst)
        (state == ST_CAP_IR) |=> (ir_sh == 3'b001));

    // R2
    ir_reset_load_chk: assert property (@(posedge tck) disable iff (por_rst)
        (state == ST_TLR) |=> (ir_q == OP_IDCODE));

    // R7
    ir_hold_chk: assert property (@(posedge tck) disable iff (por_rst)
        (state != ST_UPD_IR && state != ST_TLR) |=> $stable(ir_q));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import sram_tap_pkg::*;
#(
    parameter int              BSR_LEN = 75,
    parameter logic [ID_W-1:0] ID_WORD = 32'h0000_0001
) (
    input  logic               tck,
    input  logic               por_rst,
    input  logic               tdi,
    input  tap_state_e         state,
    input  dr_sel_e            sel,
    input  logic [BSR_LEN-1:0] bscan_in,
    output logic               dr_lsb
);
    logic               byp_q;
    logic [ID_W-1:0]    id_sh;
    logic [BSR_LEN-1:0] bsr_sh;

    wire cap   = (state == ST_CAP_DR);
    wire shift = (state == ST_SH_DR);

    always_ff @(posedge tck) begin
        if (por_rst) begin
            byp_q <= 1'b0;
        end else if (sel == SEL_BYP) begin
            if (cap)        byp_q <= 1'b0;
            else if (shift) byp_q <= tdi;
        end
    end

    always_ff @(posedge tck) begin
        if (por_rst) begin
            id_sh <= '0;
        end else if (sel == SEL_ID) begin
            if (cap)        id_sh <= ID_WORD;
            else if (shift) id_sh <= {tdi, id_sh[ID_W-1:1]};
        end
    end

    always_ff @(posedge tck) begin
        if (por_rst) begin
            bsr_sh <= '0;
        end else if (sel == SEL_BSR) begin
            if (cap)        bsr_sh <= bscan_in;
            else if (shift) bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
        end
    end

    always_comb begin
        case (sel)
            SEL_ID:  dr_lsb = id_sh[0];
            SEL_BSR: dr_lsb = bsr_sh[0];
            default: dr_lsb = byp_q;
        endcase
    end

    // R5
    byp_capture_chk: assert property (@(posedge tck) disable iff (por_rst)
        (cap && sel == SEL_BYP) |=> !byp_q);

    // R4
    id_marker_chk: assert property (@(posedge tck) disable iff (por_rst)
        (cap && sel == SEL_ID) |=> (id_sh[0] == 1'b1));

    // R9
    bsr_pause_hold_chk: assert property (@(posedge tck) disable iff (por_rst)
        (state == ST_PAU_DR) |=> $stable(bsr_sh));

endmodule

// File: rtl/sram_tap.sv
module sram_tap
    import sram_tap_pkg::*;
#(
    parameter int          BSR_LEN   = 75,
    parameter logic [3:0]  ID_REV    = 4'h2,
    parameter logic [9:0]  ID_CFG    = 10'h0A4,
    parameter logic [5:0]  ID_VEND   = 6'h00,
    parameter logic [10:0] ID_MFR    = 11'h2A5
) (
    input  logic               tck,
    input  logic               por_rst,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] bscan_in,
    output logic               tdo,
    output logic               tdo_en,
    output logic               dq_hiz
);
    localparam idcode_t ID_FIELDS = '{rev: ID_REV, cfg: ID_CFG, vend: ID_VEND,
                                      mfr: ID_MFR, marker: 1'b1};
    localparam logic [ID_W-1:0] ID_WORD = ID_FIELDS;

    tap_state_e state;
    tap_op_e    ir_q;
    logic       ir_lsb;
    logic       dr_lsb;
    op_decode_t dec;

    tap_fsm #(.RESET_RUN(5)) u_fsm (
        .tck     (tck),
        .por_rst (por_rst),
        .tms     (tms),
        .state   (state)
    );

    tap_ir u_ir (
        .tck     (tck),
        .por_rst (por_rst),
        .tdi     (tdi),
        .state   (state),
        .ir_q    (ir_q),
        .ir_lsb  (ir_lsb)
    );

    assign dec    = op_decode(ir_q);
    assign dq_hiz = dec.hiz;

    tap_dr #(.BSR_LEN(BSR_LEN), .ID_WORD(ID_WORD)) u_dr (
        .tck      (tck),
        .por_rst  (por_rst),
        .tdi      (tdi),
        .state    (state),
        .sel      (dec.sel),
        .bscan_in (bscan_in),
        .dr_lsb   (dr_lsb)
    );

    // output stage launched on the falling edge
    always_ff @(negedge tck) begin
        if (por_rst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (state == ST_SH_IR) || (state == ST_SH_DR);
            case (state)
                ST_SH_IR: tdo <= ir_lsb;
                ST_SH_DR: tdo <= dr_lsb;
                default:  tdo <= 1'b0;
            endcase
        end
    end

    // R1
    tlr_bus_drive_chk: assert property (@(posedge tck) disable iff (por_rst)
        (state == ST_TLR) |=> !dq_hiz);

    // R8
    tdo_posedge_stable_chk: assert property (@(posedge tck) disable iff (por_rst)
        $stable(tdo_en) || $past(state == ST_CAP_DR || state == ST_CAP_IR ||
                                  state == ST_SH_DR  || state == ST_SH_IR ||
                                  state == ST_EX2_DR || state == ST_EX2_IR));

endmodule

// File: tb/sram_tap_tb.sv
`timescale 1ns/1ps
module sram_tap_tb;
    localparam int BSR_LEN = 75;
    localparam logic [31:0] EXP_ID = 32'h2290054B;

    logic tck = 1'b0;
    logic por_rst, tms, tdi;
    logic [BSR_LEN-1:0] bscan_in;
    logic tdo, tdo_en, dq_hiz;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    logic en_early, en_shift;

    always #2.5 tck = ~tck;

    sram_tap u_dut (
        .tck(tck), .por_rst(por_rst), .tms(tms), .tdi(tdi),
        .bscan_in(bscan_in), .tdo(tdo), .tdo_en(tdo_en), .dq_hiz(dq_hiz)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive inputs for the next rising edge, return TDO after the falling edge
    task automatic clk(input logic tms_v, input logic tdi_v, output logic t);
        tms = tms_v; tdi = tdi_v;
        @(posedge tck); #3;
        t = tdo;
    endtask

    task automatic idle_n(input int n);
        logic t;
        for (int i = 0; i < n; i++) clk(1'b0, 1'b1, t);
    endtask

    task automatic shift_ir(input logic [2:0] code, output logic [2:0] cap);
        logic t;
        clk(1, 1, t); clk(1, 1, t); clk(0, 1, t);
        clk(0, 1, t); cap[0] = t;
        for (int i = 0; i < 3; i++) begin
            clk(i == 2, code[i], t);
            if (i < 2) cap[i+1] = t;
        end
        clk(1, 1, t); clk(0, 1, t);
    endtask

    task automatic shift_dr(input int n, input logic [127:0] din, output logic [127:0] dout);
        logic t;
        dout = '0;
        clk(1, 1, t); clk(0, 1, t);
        tms = 0; tdi = 1;
        @(posedge tck); #1 en_early = tdo_en;
        #2 dout[0] = tdo; en_shift = tdo_en;
        for (int i = 0; i < n; i++) begin
            clk(i == n - 1, din[i], t);
            if (i < n - 1) dout[i+1] = t;
        end
        clk(1, 1, t); clk(0, 1, t);
    endtask

    function automatic int exp_len(input logic [2:0] c);
        if (c == 3'b001) return 32;
        if (c == 3'b000 || c == 3'b010 || c == 3'b100) return BSR_LEN;
        return 1;
    endfunction

    function automatic logic exp_hiz(input logic [2:0] c);
        return (c == 3'b000 || c == 3'b010);
    endfunction

    function automatic logic [127:0] exp_scan(input logic [2:0] c, input logic [BSR_LEN-1:0] pins,
                                              input logic [127:0] din, input int n);
        logic [127:0] cap, r;
        int len;
        len = exp_len(c);
        if (c == 3'b001) cap = {96'd0, EXP_ID};
        else if (len == BSR_LEN) cap = {53'd0, pins};
        else cap = '0;
        r = '0;
        for (int i = 0; i < n; i++) r[i] = (i < len) ? cap[i] : din[i - len];
        return r;
    endfunction

    function automatic logic [127:0] mask(input int n);
        logic [127:0] m;
        m = '0;
        for (int i = 0; i < n; i++) m[i] = 1'b1;
        return m;
    endfunction

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [2:0]   cap;
        logic [127:0] dout, din, ex;
        logic t;
        void'($urandom(32'd7341));
        por_rst = 1; tms = 1; tdi = 1; bscan_in = '0;
        repeat (4) @(posedge tck);
        #1 por_rst = 0;
        @(posedge tck); #3;

        // R1: reset state
        chk(tdo_en == 0, "R1 tdo_en after reset", tdo_en, 0);
        chk(dq_hiz == 0, "R1 dq_hiz after reset", dq_hiz, 0);
        idle_n(2);
        shift_dr(32, '0, dout);
        chk(dout[31:0] == EXP_ID, "R1/R4 identity scan", dout[31:0], EXP_ID);
        chk(en_early == 0 && en_shift == 1, "R8 tdo_en falling-edge launch",
            {en_early, en_shift}, 2'b01);

        // R4: identity fields
        chk(dout[31:28] == 4'h2 && dout[0] == 1'b1 && dout[11:1] == 11'h2A5,
            "R4 identity fields", dout[31:0], EXP_ID);

        // R3 and R7 with EXTEST
        shift_ir(3'b000, cap);
        chk(cap == 3'b001, "R3 capture pattern", cap, 3'b001);
        chk(dq_hiz == 1, "R7 hiz for 000", dq_hiz, 1);

        // R6/R10: boundary capture and pass-through length
        bscan_in = {11'h5A3, $urandom, $urandom};
        din = {$urandom, $urandom, $urandom, $urandom};
        shift_dr(BSR_LEN + 8, din, dout);
        ex = exp_scan(3'b000, bscan_in, din, BSR_LEN + 8);
        chk((dout & mask(BSR_LEN + 8)) == ex, "R6/R10 boundary scan", dout, ex);

        // R2: reset from mid Shift-DR after loading BYPASS
        shift_ir(3'b011, cap);
        chk(dq_hiz == 0, "R7 hiz for 011", dq_hiz, 0);
        clk(1, 1, t); clk(0, 1, t); clk(0, 1, t);
        for (int i = 0; i < 5; i++) clk(1, 1, t);
        chk(tdo_en == 0, "R2 tdo_en in reset", tdo_en, 0);
        clk(0, 1, t);
        shift_dr(32, '0, dout);
        chk(dout[31:0] == EXP_ID, "R2 identity after TMS reset", dout[31:0], EXP_ID);

        // R2 with SAMPLE-Z active
        shift_ir(3'b010, cap);
        chk(dq_hiz == 1, "R7 hiz for 010", dq_hiz, 1);
        for (int i = 0; i < 5; i++) clk(1, 1, t);
        clk(0, 1, t);
        chk(dq_hiz == 0, "R2 hiz cleared by TMS reset", dq_hiz, 0);

        // R9: bypass holds across pause, R5 capture zero
        shift_ir(3'b101, cap);
        clk(1, 1, t); clk(0, 1, t); clk(0, 1, t);
        chk(t == 0, "R5 bypass captures 0", t, 0);
        clk(1, 1, t);
        clk(0, 0, t);
        chk(tdo_en == 0, "R8 tdo_en low in pause", tdo_en, 0);
        clk(1, 0, t); clk(0, 0, t);
        chk(t == 1, "R9 bypass held through pause", t, 1);
        clk(1, 0, t); clk(1, 0, t); clk(0, 0, t);

        // R7 stays put during IR shift until Update-IR
        shift_ir(3'b100, cap);
        chk(dq_hiz == 0, "R7 hiz for 100", dq_hiz, 0);

        // random instructions and data
        for (int k = 0; k < 40; k++) begin
            logic [2:0] code;
            int n;
            code = 3'($urandom % 8);
            shift_ir(code, cap);
            chk(cap == 3'b001, "R3 capture pattern random", cap, 3'b001);
            chk(dq_hiz == exp_hiz(code), "R7 hiz random", {code, dq_hiz}, {code, exp_hiz(code)});
            bscan_in = {11'($urandom), $urandom, $urandom};
            din = {$urandom, $urandom, $urandom, $urandom};
            n = exp_len(code) + 1 + int'($urandom % 8);
            shift_dr(n, din, dout);
            ex = exp_scan(code, bscan_in, din, n);
            chk((dout & mask(n)) == ex, "R5/R6/R10 random scan", dout, ex);
            chk(en_early == 0 && en_shift == 1, "R8 random tdo_en timing",
                {en_early, en_shift}, 2'b01);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule